// File: doc/BRIEF.md
# Single-Precision Two-Operand NaN Result Selector

This block produces the result word of a two-input single-precision arithmetic operation for the case where at least one operand is a NaN. It classifies each operand as quiet NaN, signaling NaN or ordinary value. It picks one operand according to a selectable propagation policy and returns it. If the picked word is a signaling NaN, it is turned into a quiet one first. Alongside the result it reports an invalid-operation flag. Issuing the arithmetic, and handling operand pairs with no NaN in them, is the job of the surrounding datapath.

Three policies are available. The first ranks signaling NaNs above quiet ones and prefers operand a within each rank. The second simply prefers operand a whenever it is a NaN. The third compares significand magnitudes, with the sign deciding a tie. A separate control forces the canonical default NaN in place of any propagated payload. The result and flag are captured in one register stage, qualified by a valid strobe.

Top module: `spnan_select`

## Requirements
- R1: A 32-bit word is a quiet NaN when bits 30..23 are all ones and bit 22 is one. It is a signaling NaN when bits 30..23 are all ones, bit 22 is zero and bits 21..0 are not all zero. All other words, infinities included, are not NaNs.
- R2: `invalid` is one exactly when operand a or operand b is a signaling NaN, in every policy and in default-NaN mode.
- R3: When `dflt_nan` is one, `result` is 0x7FC00000 regardless of the operands and the policy.
- R4: Policy 0 (`rule_sel`=0) returns a if a is signaling, else b if b is signaling, else a if a is quiet, else b.
- R5: Policy 1 (`rule_sel`=1) returns a if a is any NaN, else b.
- R6: Policy 2 (`rule_sel`=2) applies these rules. Between two signaling NaNs or two quiet NaNs, it returns the one with the larger significand. Between a signaling and a quiet NaN, it returns the quiet one. Between a NaN and a non-NaN, it returns the NaN.
- R7: Under policy 2, significand size is compared on bits 30..0 taken as an unsigned number. On equality, a counts as larger exactly when the full word a is below the full word b as unsigned, meaning a is positive and b is negative.
- R8: A returned word that is a signaling NaN has bit 22 set and every other bit kept. A returned quiet NaN is passed through unchanged.
- R9: `out_valid` equals `in_valid` delayed by one clock. `result` and `invalid` update only on a cycle with `in_valid` high and hold otherwise.
- R10: `rule_sel`=3 behaves exactly like policy 0.
- R11: After synchronous reset, `out_valid`, `result` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rule_sel | input | 2 | Propagation policy: 0 signaling first, 1 a first, 2 magnitude, 3 same as 0 |
| dflt_nan | input | 1 | Force the default NaN as the result |
| out_valid | output | 1 | Result and flag are valid |
| result | output | 32 | Selected, quieted NaN word |
| invalid | output | 1 | An operand was a signaling NaN |

## Verification
The bench aims at words that sit just next to the NaN boundary. An infinity and a signaling NaN with payload 1 are among them. A wrong classifier would treat the infinity as a NaN or miss the minimal signaling NaN. The bench checks the magnitude policy with equal magnitudes and opposite signs, in both operand orders. A tie-break with the wrong sense would return the negative word. It also drives mixed quiet/signaling pairs in every policy. A priority error there shows up as the wrong operand or a payload that was not quieted. The bench also checks that default-NaN mode still raises the invalid flag and that the outputs hold when no valid strobe arrives.

// File: rtl/spnan_pkg.sv
package spnan_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int MAG_W  = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MAG_W-1:0]  mag_t;

    typedef enum logic [1:0] {
        RULE_SIG_FIRST = 2'd0,
        RULE_A_FIRST   = 2'd1,
        RULE_MAGNITUDE = 2'd2,
        RULE_SIG_ALIAS = 2'd3
    } rule_e;

    typedef struct packed {
        logic is_nan;
        logic quiet;
        logic sig;
    } nan_cls_t;

    localparam word_t QUIET_MASK  = word_t'(1) << QBIT;
    localparam word_t DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic nan_cls_t classify(input word_t w);
        nan_cls_t c;
        logic     exp_ones;
        exp_ones = &w[WORD_W-2:FRAC_W];
        c.quiet  = exp_ones & w[QBIT];
        c.sig    = exp_ones & ~w[QBIT] & (|w[QBIT-1:0]);
        c.is_nan = c.quiet | c.sig;
        return c;
    endfunction

    function automatic word_t quieten(input word_t w);
        return w | QUIET_MASK;
    endfunction

endpackage

// File: rtl/spnan_classify.sv
module spnan_classify
    import spnan_pkg::*;
(
    input  word_t    word_i,
    output nan_cls_t cls_o
);
    assign cls_o = classify(word_i);

    always_comb begin
        // R1
        cls_excl_chk: assert (!(cls_o.quiet && cls_o.sig));
    end
endmodule

// File: rtl/spnan_magcmp.sv
module spnan_magcmp
    import spnan_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    output logic  a_larger_o
);
    mag_t mag_a, mag_b;
    logic mag_eq;

    assign mag_a      = a_i[MAG_W-1:0];
    assign mag_b      = b_i[MAG_W-1:0];
    assign mag_eq     = (mag_a == mag_b);
    assign a_larger_o = (mag_a > mag_b) | (mag_eq & (a_i < b_i));

    always_comb begin
        // R7
        tie_sign_chk: assert (!(mag_eq && a_larger_o) || (!a_i[WORD_W-1] && b_i[WORD_W-1]));
    end
endmodule

// File: rtl/spnan_choose.sv
module spnan_choose
    import spnan_pkg::*;
(
    input  rule_e    rule_i,
    input  nan_cls_t cls_a_i,
    input  nan_cls_t cls_b_i,
    input  logic     a_larger_i,
    output logic     pick_b_o
);
    always_comb begin
        unique case (rule_i)
            RULE_A_FIRST: pick_b_o = ~cls_a_i.is_nan;
            RULE_MAGNITUDE: begin
                if (cls_a_i.sig)
                    pick_b_o = cls_b_i.sig ? ~a_larger_i : cls_b_i.quiet;
                else if (cls_a_i.quiet)
                    pick_b_o = cls_b_i.quiet ? ~a_larger_i : 1'b0;
                else
                    pick_b_o = 1'b1;
            end
            default: begin
                if (cls_a_i.sig)        pick_b_o = 1'b0;
                else if (cls_b_i.sig)   pick_b_o = 1'b1;
                else if (cls_a_i.quiet) pick_b_o = 1'b0;
                else                    pick_b_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        // R6
        mag_prefers_quiet_chk: assert (!(rule_i == RULE_MAGNITUDE && cls_a_i.sig && cls_b_i.quiet) || pick_b_o);
    end
endmodule

// File: rtl/spnan_select.sv
module spnan_select
    import spnan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [1:0]  rule_sel,
    input  logic        dflt_nan,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        invalid
);
    word_t    opnd [2];
    nan_cls_t cls  [2];
    logic     a_larger, pick_b, chosen_sig, flag_nxt;
    word_t    chosen, word_nxt;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        spnan_classify u_cls (.word_i(opnd[gi]), .cls_o(cls[gi]));
    end

    spnan_magcmp u_cmp (.a_i(opnd[0]), .b_i(opnd[1]), .a_larger_o(a_larger));

    spnan_choose u_pick (
        .rule_i    (rule_e'(rule_sel)),
        .cls_a_i   (cls[0]),
        .cls_b_i   (cls[1]),
        .a_larger_i(a_larger),
        .pick_b_o  (pick_b)
    );

    assign chosen     = pick_b ? opnd[1] : opnd[0];
    assign chosen_sig = pick_b ? cls[1].sig : cls[0].sig;
    assign word_nxt   = dflt_nan ? DEFAULT_NAN : (chosen_sig ? quieten(chosen) : chosen);
    assign flag_nxt   = cls[0].sig | cls[1].sig;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= word_nxt;
                invalid <= flag_nxt;
            end
        end
    end

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));
    // R2
    invalid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (invalid == ($past(cls[0].sig) | $past(cls[1].sig))));
    // R3
    dflt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dflt_nan) |=> (result == DEFAULT_NAN));
    // R5
    a_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dflt_nan && rule_sel == 2'd1 && cls[0].is_nan) |=> (result == quieten($past(op_a))));
    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (cls[0].is_nan || cls[1].is_nan)) |=> classify(result).quiet);
endmodule

// File: tb/spnan_select_tb.sv
`timescale 1ns/1ps
module spnan_select_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [1:0]  rule_sel;
    logic        dflt_nan;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    spnan_select dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rule_sel(rule_sel), .dflt_nan(dflt_nan), .out_valid(out_valid),
        .result(result), .invalid(invalid)
    );

    function automatic bit m_qnan(logic [31:0] w);
        return (w << 1) >= 32'hFF80_0000;
    endfunction
    function automatic bit m_snan(logic [31:0] w);
        return (w[30:22] == 9'h1FE) && (w[21:0] != 0);
    endfunction
    function automatic bit m_any(logic [31:0] w);
        return m_qnan(w) || m_snan(w);
    endfunction

    function automatic logic [31:0] m_expect(logic [31:0] a, logic [31:0] b, logic [1:0] r, bit d);
        bit takeb, alarge;
        logic [31:0] w;
        if ((a << 1) != (b << 1)) alarge = (a << 1) > (b << 1);
        else                      alarge = a < b;
        if (r == 2'd1) takeb = !m_any(a);
        else if (r == 2'd2) begin
            if (m_snan(a) && m_snan(b))      takeb = !alarge;
            else if (m_qnan(a) && m_qnan(b)) takeb = !alarge;
            else if (m_snan(a))              takeb = m_qnan(b);
            else if (m_qnan(a))              takeb = 1'b0;
            else                             takeb = 1'b1;
        end else begin
            if (m_snan(a))      takeb = 1'b0;
            else if (m_snan(b)) takeb = 1'b1;
            else if (m_qnan(a)) takeb = 1'b0;
            else                takeb = 1'b1;
        end
        w = takeb ? b : a;
        if (m_snan(w)) w[22] = 1'b1;
        if (d) w = 32'h7FC0_0000;
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] a, logic [31:0] b, logic [1:0] r, bit d, string tag);
        op_a = a; op_b = b; rule_sel = r; dflt_nan = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 valid"}, {31'b0, out_valid}, 32'd1);
        check({tag, " result"}, result, m_expect(a, b, r, d));
        check({tag, " R2 flag"}, {31'b0, invalid}, {31'b0, m_snan(a) || m_snan(b)});
    endtask

    function automatic logic [31:0] gen(int kind);
        logic [31:0] w;
        w = $urandom;
        case (kind)
            0: begin w[30:23] = 8'hFF; w[22] = 1'b1; end
            1: begin w[30:23] = 8'hFF; w[22] = 1'b0; if (w[21:0] == 0) w[0] = 1'b1; end
            2: begin w[30:23] = 8'hFF; w[22:0] = '0; end
            default: if (w[30:23] == 8'hFF) w[30] = 1'b0;
        endcase
        return w;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; rule_sel = '0; dflt_nan = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 result", result, 32'd0);
        check("R11 invalid", {31'b0, invalid}, 32'd0);
        rst = 1'b0;

        // R4 quiet a, signaling b: b silenced
        run_op(32'h7FC1_2345, 32'h7F80_0001, 2'd0, 1'b0, "R4 qa-sb");
        check("R8 silenced payload", result, 32'h7FC0_0001);
        // R5 same pair: a returned
        run_op(32'h7FC1_2345, 32'h7F80_0001, 2'd1, 1'b0, "R5 qa-sb");
        check("R5 a kept", result, 32'h7FC1_2345);
        // R6 same pair: quiet one wins
        run_op(32'h7FC1_2345, 32'h7F80_0001, 2'd2, 1'b0, "R6 qa-sb");
        // R7 tie, a positive: a wins
        run_op(32'h7FC0_0001, 32'hFFC0_0001, 2'd2, 1'b0, "R7 tie pos-a");
        check("R7 tie pos-a word", result, 32'h7FC0_0001);
        // R7 tie, a negative: b wins
        run_op(32'hFFC0_0001, 32'h7FC0_0001, 2'd2, 1'b0, "R7 tie neg-a");
        check("R7 tie neg-a word", result, 32'h7FC0_0001);
        // R1 infinity is not a NaN
        run_op(32'h7F80_0000, 32'h7FC0_0005, 2'd1, 1'b0, "R1 inf");
        check("R1 inf word", result, 32'h7FC0_0005);
        // R8 non-NaN a, signaling b
        run_op(32'h3F80_0000, 32'hFF81_2345, 2'd1, 1'b0, "R8 num-sb");
        check("R8 word", result, 32'hFFC1_2345);
        // R3 default mode keeps the flag
        run_op(32'h7F80_0001, 32'hFFC0_0000, 2'd2, 1'b1, "R3 dflt");
        check("R3 flag", {31'b0, invalid}, 32'd1);
        // R10 mode 3 alias
        run_op(32'h7FC0_0abc, 32'h7FA0_0000, 2'd3, 1'b0, "R10 alias");
        check("R10 word", result, 32'h7FE0_0000);
        // R9 hold without valid
        op_a = 32'h7F80_0002; op_b = 32'h7F80_0003; dflt_nan = 1'b1;
        @(negedge clk);
        check("R9 hold valid", {31'b0, out_valid}, 32'd0);
        check("R9 hold result", result, 32'h7FE0_0000);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            logic [1:0]  r;
            a = gen($urandom_range(0, 3));
            b = gen($urandom_range(0, 3));
            if (!m_any(a) && !m_any(b)) a = gen(0);
            r = 2'($urandom_range(0, 3));
            case (r)
                2'd0: run_op(a, b, r, ($urandom_range(0, 7) == 0), "R4 rand");
                2'd1: run_op(a, b, r, ($urandom_range(0, 7) == 0), "R5 rand");
                2'd2: run_op(a, b, r, ($urandom_range(0, 7) == 0), "R6 rand");
                default: run_op(a, b, r, ($urandom_range(0, 7) == 0), "R10 rand");
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule